// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decode

This block is the serial test port of a chip. A sixteen-state controller follows the mode-select line on each rising edge of the test clock and moves data through one of four shift paths: a three-bit instruction register, a one-bit pass-through register, a 32-bit identity register and a boundary chain. The boundary chain holds one cell per system input pin, plus one data cell and one enable cell per system output pin.

The latched instruction selects the shift path. It also selects what drives the output pins and their enables. The core's own values pass straight through, the boundary chain's update stage can drive the pins, the pins can be held frozen while the one-bit path is in use, or every enable can be released. An asynchronous active-low test reset is released on the test clock through a two-stage synchronizer.

Top module: `jtag_tap_port`

## Requirements
- R1: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. Driving trst_n low forces that state at once, clears tdo_oe and restores normal pin control without any clock.
- R2: The instruction register is 3 bits wide and is shifted least significant bit first. Capture-IR loads 3'b001, so the first three bits seen on tdo in Shift-IR are 1, 0, 0.
- R3: Entering Test-Logic-Reset loads the identity instruction (code 001). A data scan straight after reset returns the identity word.
- R4: Instruction codes are 000 external test, 001 identity, 010 sample/preload, 011 clamp, 101 high-impedance and 111 bypass. Codes 100 and 110 act as bypass. A new code takes effect only on the falling TCK edge in Update-IR, so pin control stays unchanged through Shift-IR and Exit1-IR.
- R5: The identity word is {version[31:28], part[27:12], manufacturer[11:1], 1'b1}, with all three fields set by parameters. It is shifted out bit 0 first.
- R6: The pass-through register captures 0 and delays tdi by exactly one TCK period on the way to tdo.
- R7: Boundary chain bit 0 is nearest tdo and tdi enters at the top bit. Bits [NIN-1:0] capture pin_in, the next NOUT bits capture the driven pin_out, and the top NOUT bits capture pin_oe.
- R8: Under external test (000), pin_out and pin_oe come from the data cells and enable cells of the update stage. The update stage is loaded on the falling TCK edge in Update-DR.
- R9: Under identity, sample/preload and bypass codes, pin_out equals core_out and pin_oe equals core_oe. Sample/preload still loads the update stage, which becomes visible after a switch to external test or clamp. pin_in reaches core_in unchanged under every code.
- R10: Under clamp (011), the shift path is the one-bit register. The pins come from the update stage and do not change while clamp is active, whatever the core drives.
- R11: Under high-impedance (101), every bit of pin_oe is 0 and the shift path is the one-bit register.
- R12: tdo changes only on the falling TCK edge. tdo_oe is high only while the controller is in Shift-IR or Shift-DR, and tdo is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, high impedance when not shifting |
| tdo_oe | output | 1 | Drive enable for tdo |
| pin_in | input | NIN | Levels at the system input pins |
| core_in | output | NIN | Input levels passed on to the core |
| core_out | input | NOUT | Data the core wants on the output pins |
| core_oe | input | NOUT | Enables the core wants on the output pins |
| pin_out | output | NOUT | Data driven toward the output pads |
| pin_oe | output | NOUT | Enables driven toward the output pads |

## Verification
Most internal faults show up at the ports within one scan. A wrong controller state or instruction latch shows in the very next pin-control value or the next tdo bit, because every data scan is compared bit by bit against a model of the selected path's length and capture content. A bad update stage or a bad decode shows on pin_out/pin_oe on the falling edge of Update-DR or Update-IR. Pin values are also checked at Exit1-IR, which catches a decode that switches early. An asynchronous-reset fault shows on tdo_oe and the pins with no clock edge at all.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_EX2_DR = 4'h0, ST_EX1_DR = 4'h1, ST_SH_DR  = 4'h2, ST_PA_DR  = 4'h3,
    ST_SEL_IR = 4'h4, ST_UPD_DR = 4'h5, ST_CAP_DR = 4'h6, ST_SEL_DR = 4'h7,
    ST_EX2_IR = 4'h8, ST_EX1_IR = 4'h9, ST_SH_IR  = 4'hA, ST_PA_IR  = 4'hB,
    ST_RTI    = 4'hC, ST_UPD_IR = 4'hD, ST_CAP_IR = 4'hE, ST_TLR    = 4'hF
  } tap_state_e;

  typedef enum logic [2:0] {
    OP_EXTEST, OP_IDCODE, OP_SAMPLE, OP_CLAMP, OP_HIGHZ, OP_BYPASS
  } tap_op_e;

  localparam logic [IR_W-1:0] CODE_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] CODE_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] CODE_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] CODE_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] CODE_HIGHZ  = 3'b101;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  function automatic tap_op_e decode_op(input logic [IR_W-1:0] code);
    case (code)
      CODE_EXTEST: decode_op = OP_EXTEST;
      CODE_IDCODE: decode_op = OP_IDCODE;
      CODE_SAMPLE: decode_op = OP_SAMPLE;
      CODE_CLAMP:  decode_op = OP_CLAMP;
      CODE_HIGHZ:  decode_op = OP_HIGHZ;
      default:     decode_op = OP_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              W          = IR_W,
  parameter logic [W-1:0]    RESET_CODE = CODE_IDCODE,
  parameter logic [W-1:0]    CAP_PAT    = IR_CAPTURE
) (
  input  logic         tck,
  input  logic         rst_n,
  input  tap_state_e   state,
  input  logic         tdi,
  output logic [W-1:0] ir_cur,
  output logic         ir_so
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;
  logic [W-1:0] cur_d;
  logic         cur_en;

  always_comb begin
    sr_en = (state == ST_CAP_IR) || (state == ST_SH_IR);
    sr_d  = (state == ST_CAP_IR) ? CAP_PAT : {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= CAP_PAT;
    else if (sr_en) sr_q <= sr_d;
  end

  always_comb begin
    cur_en = (state == ST_TLR) || (state == ST_UPD_IR);
    cur_d  = (state == ST_TLR) ? RESET_CODE : sr_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      ir_cur <= RESET_CODE;
    else if (cur_en) ir_cur <= cur_d;
  end

  assign ir_so = sr_q[0];
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import tap_pkg::*;
#(
  parameter int NIN  = 4,
  parameter int NOUT = 4,
  localparam int LEN = NIN + 2 * NOUT
) (
  input  logic           tck,
  input  logic           rst_n,
  input  tap_state_e     state,
  input  logic           sel,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] upd_q,
  output logic           so
);
  logic [LEN-1:0] sh_q, sh_d;
  logic           sh_en;
  logic           upd_en;

  always_comb begin
    sh_en = sel && ((state == ST_CAP_DR) || (state == ST_SH_DR));
    sh_d  = (state == ST_CAP_DR) ? cap_vec : {tdi, sh_q[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign upd_en = sel && (state == ST_UPD_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= sh_q;
  end

  assign so = sh_q[0];
endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
  import tap_pkg::*;
#(
  parameter int          NIN      = 4,
  parameter int          NOUT     = 4,
  parameter logic [3:0]  ID_VER   = 4'h3,
  parameter logic [15:0] ID_PART  = 16'hA5C1,
  parameter logic [10:0] ID_MANUF = 11'h2B7
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NIN-1:0]  pin_in,
  output logic [NIN-1:0]  core_in,
  input  logic [NOUT-1:0] core_out,
  input  logic [NOUT-1:0] core_oe,
  output logic [NOUT-1:0] pin_out,
  output logic [NOUT-1:0] pin_oe
);
  localparam int          LEN    = NIN + 2 * NOUT;
  localparam int          OUT_LO = NIN;
  localparam int          OE_LO  = NIN + NOUT;
  localparam logic [31:0] ID_VAL = {ID_VER, ID_PART, ID_MANUF, 1'b1};

  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir_cur;
  logic            ir_so;
  tap_op_e         op;
  logic            sel_bsr, sel_id, sel_byp;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir #(.W(IR_W), .RESET_CODE(CODE_IDCODE), .CAP_PAT(IR_CAPTURE)) u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_cur(ir_cur), .ir_so(ir_so)
  );

  always_comb begin
    op      = decode_op(ir_cur);
    sel_bsr = (op == OP_EXTEST) || (op == OP_SAMPLE);
    sel_id  = (op == OP_IDCODE);
    sel_byp = !sel_bsr && !sel_id;
  end

  logic [LEN-1:0] cap_vec, upd_q;
  logic           bsr_so;

  assign cap_vec = {pin_oe, pin_out, pin_in};

  tap_bsr #(.NIN(NIN), .NOUT(NOUT)) u_bsr (
    .tck(tck), .rst_n(rst_n), .state(state), .sel(sel_bsr), .tdi(tdi),
    .cap_vec(cap_vec), .upd_q(upd_q), .so(bsr_so)
  );

  logic       byp_q, byp_d, byp_en;

  always_comb begin
    byp_en = sel_byp && ((state == ST_CAP_DR) || (state == ST_SH_DR));
    byp_d  = (state == ST_SH_DR) && tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  logic [31:0] id_q, id_d;
  logic        id_en;

  always_comb begin
    id_en = sel_id && ((state == ST_CAP_DR) || (state == ST_SH_DR));
    id_d  = (state == ST_CAP_DR) ? ID_VAL : {tdi, id_q[31:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_VAL;
    else if (id_en) id_q <= id_d;
  end

  logic dr_so, tdo_d, tdo_q, oe_d, oe_q;

  always_comb begin
    if (sel_bsr)     dr_so = bsr_so;
    else if (sel_id) dr_so = id_q[0];
    else             dr_so = byp_q;
    tdo_d = (state == ST_SH_IR) ? ir_so : dr_so;
    oe_d  = (state == ST_SH_IR) || (state == ST_SH_DR);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo_oe = oe_q;
  assign tdo    = oe_q ? tdo_q : 1'bz;

  assign core_in = pin_in;

  for (genvar p = 0; p < NOUT; p++) begin : g_pin
    always_comb begin
      case (op)
        OP_EXTEST, OP_CLAMP: begin
          pin_out[p] = upd_q[OUT_LO + p];
          pin_oe[p]  = upd_q[OE_LO + p];
        end
        OP_HIGHZ: begin
          pin_out[p] = core_out[p];
          pin_oe[p]  = 1'b0;
        end
        default: begin
          pin_out[p] = core_out[p];
          pin_oe[p]  = core_oe[p];
        end
      endcase
    end
  end
endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import tap_pkg::*;
#(
  parameter int NOUT = 4
) (
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input logic            tdi,
  input logic            tdo,
  input logic            tdo_oe,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_cur,
  input logic [NOUT-1:0] pin_out,
  input logic [NOUT-1:0] pin_oe
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= 3'd0;
    else if (!tms)       hi_cnt <= 3'd0;
    else if (hi_cnt < 5) hi_cnt <= hi_cnt + 3'd1;
  end

  logic is_byp;
  assign is_byp = (ir_cur == 3'b011) || (ir_cur == 3'b100) || (ir_cur == 3'b101)
               || (ir_cur == 3'b110) || (ir_cur == 3'b111);

  assert_tlr_reach_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> (state == ST_TLR));

  assert_ir_update_only_R4: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_cur) |-> ((state == ST_UPD_IR) || (state == ST_TLR)));

  assert_bypass_delay_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (is_byp && $past(state) == ST_SH_DR && state == ST_SH_DR) |-> (tdo == $past(tdi)));

  assert_clamp_frozen_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_cur == 3'b011 && $past(ir_cur) == 3'b011) |-> ($stable(pin_out) && $stable(pin_oe)));

  assert_highz_off_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_cur == 3'b101) |-> (pin_oe == '0));

  assert_tdo_enable_R12: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == ST_SH_DR) || (state == ST_SH_IR)));
endmodule

bind jtag_tap_port tap_checker #(.NOUT(NOUT)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
  .state(state), .ir_cur(ir_cur), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/jtag_tap_port_test.sv
module jtag_tap_port_test;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + 2 * NO;
  localparam logic [31:0] IDV = {4'h3, 16'hA5C1, 11'h2B7, 1'b1};

  logic tck, trst_n, tms, tdi, tdo, tdo_oe;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] core_out, core_oe, pin_out, pin_oe;

  jtag_tap_port #(.NIN(NI), .NOUT(NO), .ID_VER(4'h3), .ID_PART(16'hA5C1),
                  .ID_MANUF(11'h2B7)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial tck = 1'b0;
  always #2.5 tck = ~tck;

  int checks = 0, errors = 0, r12_bad = 0;
  bit done = 0;
  logic [2:0]   cur_code;
  logic [L-1:0] upd_m;
  logic [NO-1:0] snap_out, snap_oe;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_bsr(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010);
  endfunction

  function automatic logic [2*NO-1:0] exp_pins(input logic [2:0] c, input logic [L-1:0] u,
      input logic [NO-1:0] co, input logic [NO-1:0] ce);
    if (c == 3'b000 || c == 3'b011) return {u[NI+NO +: NO], u[NI +: NO]};
    if (c == 3'b101) return {{NO{1'b0}}, co};
    return {ce, co};
  endfunction

  function automatic string pin_tag(input logic [2:0] c);
    case (c)
      3'b000:  return "R8";
      3'b011:  return "R10";
      3'b101:  return "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic string dr_tag(input logic [2:0] c);
    if (is_bsr(c)) return "R7";
    if (c == 3'b001) return "R5";
    return "R6";
  endfunction

  task automatic check_pins(input string what);
    logic [2*NO-1:0] e;
    e = exp_pins(cur_code, upd_m, core_out, core_oe);
    chk(pin_tag(cur_code), {56'd0, pin_oe, pin_out}, {56'd0, e}, what);
    chk("R9", {60'd0, core_in}, {60'd0, pin_in}, "core_in follows pin_in");
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    tms = m; tdi = d; o = tdo; oe = tdo_oe;
    @(posedge tck); #1;
    if (oe && tdo !== o) r12_bad++;
    @(negedge tck); #1;
  endtask

  task automatic go_reset();
    logic o, oe;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, oe);
    cur_code = 3'b001;
    step(1'b0, 1'b0, o, oe);
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] got);
    logic o, oe;
    step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, oe);
      got[i] = o;
      chk("R12", {63'd0, oe}, 64'd1, "tdo_oe in Shift-IR");
    end
    begin
      logic [2*NO-1:0] e;
      e = exp_pins(cur_code, upd_m, core_out, core_oe);
      chk("R4", {56'd0, pin_oe, pin_out}, {56'd0, e}, "pins before Update-IR");
    end
    step(1, 0, o, oe); step(0, 0, o, oe);
    cur_code = code;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                         output int oe_bad);
    logic o, oe;
    dout = '0; oe_bad = 0;
    step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (!oe) oe_bad++;
    end
    step(1, 0, o, oe); step(0, 0, o, oe);
  endtask

  task automatic do_dr(input string what);
    logic [63:0] din, dout, cap, exp;
    logic [2*NO-1:0] pv;
    int len, ob;
    din = {$urandom, $urandom};
    pv  = exp_pins(cur_code, upd_m, core_out, core_oe);
    if (is_bsr(cur_code)) begin len = L;  cap = {52'd0, pv, pin_in}; end
    else if (cur_code == 3'b001) begin len = 32; cap = {32'd0, IDV}; end
    else begin len = 1; cap = 64'd0; end
    exp = '0;
    for (int i = 0; i < 40; i++) exp[i] = (i < len) ? cap[i] : din[i - len];
    scan_dr(40, din, dout, ob);
    chk(dr_tag(cur_code), dout, exp, what);
    chk("R12", 64'(ob), 64'd0, "tdo_oe low during Shift-DR");
    if (is_bsr(cur_code)) upd_m = din[40-L +: L];
    check_pins({what, " pins after Update-DR"});
  endtask

  task automatic rand_pins();
    pin_in = NI'($urandom); core_out = NO'($urandom); core_oe = NO'($urandom);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] got;
    logic o, oe;
    void'($urandom(32'd1234));
    trst_n = 0; tms = 1; tdi = 0;
    pin_in = 4'h9; core_out = 4'h5; core_oe = 4'hC;
    cur_code = 3'b001; upd_m = '0;
    repeat (3) @(negedge tck);
    #1;
    chk("R12", {63'd0, tdo_oe}, 64'd0, "reset tdo_oe");
    check_pins("reset state R3");
    trst_n = 1;
    go_reset();
    chk("R12", {63'd0, tdo === 1'bz}, 64'd1, "tdo floats in Run-Test/Idle");

    scan_ir(3'b111, got);
    chk("R2", {61'd0, got}, 64'd1, "Capture-IR pattern");
    go_reset();
    do_dr("R3 identity after reset");

    scan_ir(3'b111, got); do_dr("R6 bypass");
    scan_ir(3'b100, got); do_dr("R4 code 100 bypass");
    scan_ir(3'b110, got); do_dr("R4 code 110 bypass");
    rand_pins();
    scan_ir(3'b010, got); do_dr("R9 preload");
    scan_ir(3'b000, got); check_pins("R9 preload visible in EXTEST");
    rand_pins(); do_dr("R8 extest");
    scan_ir(3'b011, got);
    rand_pins(); check_pins("R10 clamp after core change");
    do_dr("R10 clamp scan");
    scan_ir(3'b101, got); check_pins("R11 highz"); do_dr("R11 highz scan");

    for (int it = 0; it < 40; it++) begin
      logic [2:0] c;
      c = 3'($urandom);
      scan_ir(c, got);
      chk("R2", {61'd0, got}, 64'd1, "Capture-IR pattern random");
      rand_pins();
      check_pins("random pins");
      do_dr("random scan");
    end

    scan_ir(3'b000, got); do_dr("R8 before trst");
    step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe); step(0, 1, o, oe);
    trst_n = 0; #1;
    cur_code = 3'b001; upd_m = '0;
    chk("R1", {63'd0, tdo_oe}, 64'd0, "async trst clears tdo_oe");
    check_pins("R1 async trst pins");
    @(negedge tck); #1; trst_n = 1;
    go_reset();
    do_dr("R3 identity after trst");

    scan_ir(3'b000, got); rand_pins(); do_dr("R8 before tms reset");
    begin
      logic [L-1:0] capv;
      logic [2*NO-1:0] pv;
      pv = exp_pins(cur_code, upd_m, core_out, core_oe);
      capv = {pv, pin_in};
      step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
      for (int i = 0; i < 5; i++) step(1, 1'b1, o, oe);
      upd_m = {1'b1, capv[L-1:1]};
      cur_code = 3'b001;
      check_pins("R1 five TMS high resets instruction");
      step(0, 0, o, oe);
    end
    do_dr("R3 identity after tms reset");

    chk("R12", 64'(r12_bad), 64'd0, "tdo stable across rising edge");
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule